// File: doc/BRIEF.md
# Banked Output-Enable Pin Cells

This block sits between twelve macrocell outputs and twelve bidirectional pads. Each pad cell decides, with no clock and no added latency, whether its pad is driven. A per-cell 2-bit mode sets the decision. The mode can force the driver off, force it on, or hand control to one of two enable terms. The two enable terms are shared by the cell's bank. Cells 0 to 5 form the low bank and cells 6 to 11 the high bank, and each bank has its own pair of terms.

The pad itself is modelled the way an FPGA pad ring expects: a data line, an active-high enable line and a returned input line. The resolved pad value is always passed back as a feedback signal. A cell can therefore act as an output, an input, a bidirectional pin or a shared-bus driver. A cell whose driver is off holds its data line low, so a released pad carries no stale macrocell value.

Top module: `bank_oe_io`

## Requirements
- R1: Mode 2'b00 (off) holds the cell's pad_oe bit low, whatever the enable terms and the macrocell value are.
- R2: Mode 2'b01 (on) holds the cell's pad_oe bit high, whatever the enable terms are.
- R3: Mode 2'b10 makes the cell's pad_oe bit follow its bank's term A, which is oe_term bit 2*bank.
- R4: Mode 2'b11 makes the cell's pad_oe bit follow its bank's term B, which is oe_term bit 2*bank+1.
- R5: Cells 0 to 5 use bank 0 (oe_term[1:0]) and cells 6 to 11 use bank 1 (oe_term[3:2]). The other bank's terms have no effect on a cell.
- R6: While a cell's pad_oe bit is high, its pad_out bit equals its mc_out bit.
- R7: While a cell's pad_oe bit is low, its pad_out bit is 0, whatever mc_out is.
- R8: Each fb_out bit equals the matching pad_in bit in every mode, so an externally driven value on a released pad reaches the feedback.
- R9: All outputs are combinational functions of the current inputs, with no clock and no stored state.

Cell i's mode occupies cell_mode[2*i+1:2*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mc_out | input | 12 | Macrocell output value for each cell |
| cell_mode | input | 24 | Per-cell 2-bit enable mode |
| oe_term | input | 4 | Shared enable terms, {B1, A1, B0, A0} |
| pad_in | input | 12 | Resolved value seen on each pad |
| pad_out | output | 12 | Data driven toward each pad |
| pad_oe | output | 12 | Active-high driver enable for each pad |
| fb_out | output | 12 | Pad value returned to internal logic |

## Verification
The assertions take for granted that every input bit holds a known 0 or 1. They evaluate only once no input carries an unknown value. The bench drives every input from time zero and changes all inputs together between clock edges. It resolves pad_in from the design's own enable, using the cell's pad_out while enabled and an external value otherwise. That resolution mirrors a real pad and never produces a contended pad.

// File: rtl/bank_oe_io_pkg.sv
package bank_oe_io_pkg;
  typedef enum logic [1:0] {
    OE_OFF    = 2'b00,
    OE_ON     = 2'b01,
    OE_TERM_A = 2'b10,
    OE_TERM_B = 2'b11
  } oe_mode_e;

  localparam int MODE_W = 2;
  localparam int TERMS_PER_BANK = 2;
endpackage

// File: rtl/oe_select.sv
module oe_select
  import bank_oe_io_pkg::*;
(
  input  logic [MODE_W-1:0]         mode,
  input  logic [TERMS_PER_BANK-1:0] bank_terms,
  output logic                      oe
);
  always_comb begin
    unique case (oe_mode_e'(mode))
      OE_OFF:    oe = 1'b0;
      OE_ON:     oe = 1'b1;
      OE_TERM_A: oe = bank_terms[0];
      OE_TERM_B: oe = bank_terms[1];
      default:   oe = 1'b0;
    endcase
  end
endmodule

// File: rtl/pad_cell.sv
module pad_cell (
  input  logic oe,
  input  logic data,
  input  logic pad_in,
  output logic pad_out,
  output logic pad_oe,
  output logic fb
);
  // a released pad carries no macrocell data
  assign pad_out = oe & data;
  assign pad_oe  = oe;
  assign fb      = pad_in;
endmodule

// File: rtl/bank_oe_io.sv
module bank_oe_io
  import bank_oe_io_pkg::*;
#(
  parameter int NUM_BANKS      = 2,
  parameter int CELLS_PER_BANK = 6
) (
  input  logic [NUM_BANKS*CELLS_PER_BANK-1:0]        mc_out,
  input  logic [NUM_BANKS*CELLS_PER_BANK*MODE_W-1:0] cell_mode,
  input  logic [NUM_BANKS*TERMS_PER_BANK-1:0]        oe_term,
  input  logic [NUM_BANKS*CELLS_PER_BANK-1:0]        pad_in,
  output logic [NUM_BANKS*CELLS_PER_BANK-1:0]        pad_out,
  output logic [NUM_BANKS*CELLS_PER_BANK-1:0]        pad_oe,
  output logic [NUM_BANKS*CELLS_PER_BANK-1:0]        fb_out
);
  localparam int NUM_CELLS = NUM_BANKS * CELLS_PER_BANK;

  logic [NUM_CELLS-1:0] cell_oe;

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    localparam int BANK = c / CELLS_PER_BANK;

    oe_select u_sel (
      .mode       (cell_mode[c*MODE_W +: MODE_W]),
      .bank_terms (oe_term[BANK*TERMS_PER_BANK +: TERMS_PER_BANK]),
      .oe         (cell_oe[c])
    );

    pad_cell u_pad (
      .oe      (cell_oe[c]),
      .data    (mc_out[c]),
      .pad_in  (pad_in[c]),
      .pad_out (pad_out[c]),
      .pad_oe  (pad_oe[c]),
      .fb      (fb_out[c])
    );
  end
endmodule

// File: rtl/bank_oe_io_chk.sv
module bank_oe_io_chk
  import bank_oe_io_pkg::*;
#(
  parameter int NUM_BANKS      = 2,
  parameter int CELLS_PER_BANK = 6
) (
  input logic [NUM_BANKS*CELLS_PER_BANK-1:0]        mc_out,
  input logic [NUM_BANKS*CELLS_PER_BANK*MODE_W-1:0] cell_mode,
  input logic [NUM_BANKS*TERMS_PER_BANK-1:0]        oe_term,
  input logic [NUM_BANKS*CELLS_PER_BANK-1:0]        pad_in,
  input logic [NUM_BANKS*CELLS_PER_BANK-1:0]        pad_out,
  input logic [NUM_BANKS*CELLS_PER_BANK-1:0]        pad_oe,
  input logic [NUM_BANKS*CELLS_PER_BANK-1:0]        fb_out
);
  localparam int NUM_CELLS = NUM_BANKS * CELLS_PER_BANK;

  always_comb begin
    if (!$isunknown({mc_out, cell_mode, oe_term, pad_in})) begin
      for (int c = 0; c < NUM_CELLS; c++) begin
        if (cell_mode[c*MODE_W +: MODE_W] == OE_OFF)
          AST_OFF_NOT_DRIVEN: assert (!pad_oe[c]) else $error("off cell drives");  // R1
        if (cell_mode[c*MODE_W +: MODE_W] == OE_ON)
          AST_ON_DRIVEN: assert (pad_oe[c]) else $error("on cell released");  // R2
        if (pad_oe[c])
          AST_DRIVE_DATA: assert (pad_out[c] == mc_out[c]) else $error("bad data");  // R6
        if (!pad_oe[c])
          AST_RELEASED_LOW: assert (!pad_out[c]) else $error("stale data");  // R7
        AST_FEEDBACK: assert (fb_out[c] == pad_in[c]) else $error("bad feedback");  // R8
      end
    end
  end
endmodule

bind bank_oe_io bank_oe_io_chk #(
  .NUM_BANKS      (NUM_BANKS),
  .CELLS_PER_BANK (CELLS_PER_BANK)
) u_chk (
  .mc_out    (mc_out),
  .cell_mode (cell_mode),
  .oe_term   (oe_term),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .fb_out    (fb_out)
);

// File: tb/bank_oe_io_tb_top.sv
module bank_oe_io_tb_top;
  localparam int NC = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [NC-1:0]   mc_out;
  logic [2*NC-1:0] cell_mode;
  logic [3:0]      oe_term;
  logic [NC-1:0]   ext_val;
  logic [NC-1:0]   pad_in;
  logic [NC-1:0]   pad_out, pad_oe, fb_out;

  int total = 0;
  int bad = 0;

  // pad resolution: the driven value wins, else the external source
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_val);

  bank_oe_io dut_i (
    .mc_out(mc_out), .cell_mode(cell_mode), .oe_term(oe_term),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .fb_out(fb_out)
  );

  function automatic logic exp_oe(int c, logic [1:0] m, logic [3:0] t);
    int b = c / 6;
    case (m)
      2'b00: return 1'b0;
      2'b01: return 1'b1;
      2'b10: return t[2*b];
      default: return t[2*b+1];
    endcase
  endfunction

  task automatic apply(input logic [NC-1:0] mc, input logic [2*NC-1:0] md,
                       input logic [3:0] t, input logic [NC-1:0] ex);
    @(negedge clk);
    mc_out = mc; cell_mode = md; oe_term = t; ext_val = ex;
    #1;
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < NC; c++) begin
      logic eo, ed, ef;
      eo = exp_oe(c, cell_mode[2*c +: 2], oe_term);
      ed = eo & mc_out[c];
      ef = eo ? mc_out[c] : ext_val[c];
      total++;
      if (pad_oe[c] !== eo || pad_out[c] !== ed || fb_out[c] !== ef) begin
        bad++;
        $display("FAIL %s cell %0d: oe=%b out=%b fb=%b expected oe=%b out=%b fb=%b",
                 req, c, pad_oe[c], pad_out[c], fb_out[c], eo, ed, ef);
      end
    end
  endtask

  function automatic logic [2*NC-1:0] all_mode(logic [1:0] m);
    logic [2*NC-1:0] r;
    for (int c = 0; c < NC; c++) r[2*c +: 2] = m;
    return r;
  endfunction

  task automatic t_all_off;  // R1, R7, R8
    apply('1, all_mode(2'b00), 4'hF, 12'hA5C);
    check_all("R1 R7 R8 off, terms high");
    apply(12'h3C3, all_mode(2'b00), 4'h0, 12'h5A3);
    check_all("R1 R7 R8 off, terms low");
  endtask

  task automatic t_all_on;  // R2, R6
    apply(12'hF0F, all_mode(2'b01), 4'h0, 12'hFFF);
    check_all("R2 R6 on, terms low");
    apply(12'h0F0, all_mode(2'b01), 4'hF, 12'h000);
    check_all("R2 R6 on, terms high");
  endtask

  task automatic t_term_a;  // R3
    for (int t = 0; t < 16; t++) begin
      apply(12'hAAA, all_mode(2'b10), 4'(t), 12'h555);
      check_all("R3 term A");
    end
  endtask

  task automatic t_term_b;  // R4
    for (int t = 0; t < 16; t++) begin
      apply(12'h6DB, all_mode(2'b11), 4'(t), 12'h924);
      check_all("R4 term B");
    end
  endtask

  task automatic t_bank_split;  // R5
    // bank 0 terms on, bank 1 off: only cells 0..5 drive
    apply('1, all_mode(2'b10), 4'b0001, 12'h000);
    check_all("R5 bank0 A only");
    apply('1, all_mode(2'b11), 4'b1000, 12'h000);
    check_all("R5 bank1 B only");
    total++;
    if (pad_oe !== 12'hFC0) begin
      bad++;
      $display("FAIL R5 bank1 B only: oe=%h expected oe=fc0", pad_oe);
    end
  endtask

  task automatic t_mixed;  // R1..R9 mixed per-cell modes, R9 same-cycle response
    logic [2*NC-1:0] m;
    for (int c = 0; c < NC; c++) m[2*c +: 2] = 2'(c);
    apply(12'h9C6, m, 4'b0110, 12'h3A5);
    check_all("R9 mixed modes");
    apply(12'h639, m, 4'b1001, 12'hC5A);
    check_all("R9 mixed modes, terms swapped");
  endtask

  task automatic t_input_use;  // R8 released pad as input, toggling external value
    for (int v = 0; v < 4; v++) begin
      apply(12'hFFF, all_mode(2'b00), 4'hF, v[0] ? 12'hFFF : 12'h000);
      check_all("R8 input feedback");
    end
  endtask

  initial begin
    mc_out = '0; cell_mode = '0; oe_term = '0; ext_val = '0;
    #1;
    total++;
    if (pad_oe !== '0 || pad_out !== '0) begin
      bad++;
      $display("FAIL R1 initial: oe=%h out=%h expected oe=000 out=000", pad_oe, pad_out);
    end
    t_all_off();
    t_all_on();
    t_term_a();
    t_term_b();
    t_bank_split();
    t_mixed();
    t_input_use();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule